// File: doc/BRIEF.md
# Fractional Serial Bit Clock Generator

This block derives the serial bit clock for a serial peripheral master from a fast core clock. Each chip select owns an 8-bit rate field, and the block uses the field of the currently selected device. The serial clock frequency equals the core clock frequency times the rate field, divided by 512. Legal rates are powers of two from 1 to 128, so the serial clock runs between 1/512 and 1/4 of the core clock.

The rate is a step added to a 9-bit phase accumulator rather than an integer divide count. Each carry out of the accumulator marks one half period of the serial clock. A polarity input sets the idle level of the clock. The shift logic receives two one-cycle strobes: one at the leading edge, where the clock leaves its idle level, and one at the trailing edge, where it returns. The shifter chooses which strobe to sample on according to its clock phase.

Dropping the enable clears the accumulator and parks the clock at its idle level. The next enable therefore starts with the same timing every time.

Top module: `bitclk_gen`

## Requirements
- R1: While `rst` is high, `sclk` equals `cpol`, and both strobes are low.
- R2: With an effective rate field R (a power of two, 1 to 128), successive leading strobes are 512/R core cycles apart. Each trailing strobe comes 256/R cycles after the leading strobe before it. The serial clock rate is therefore core × R / 512.
- R3: `en` is sampled high at core clock edge 1, and the rate field has been stable for at least two cycles before that. The first leading strobe is then output after edge 256/R + 1. The first trailing strobe follows after edge 2·256/R + 1.
- R4: Each strobe lasts one core cycle. `lead_stb` rises in the cycle in which `sclk` leaves the idle level (`sclk` != `cpol`). `trail_stb` rises in the cycle in which `sclk` returns to `cpol`. The two strobes are never high together.
- R5: The rate field for select index i is `rate_words[8*i+7 : 8*i]`. Only the field indexed by `sel` affects the output.
- R6: A field that is not a power of two is rounded down to its highest set bit (0x50 acts as 64, 0x05 acts as 4). A field of zero produces no strobes and keeps `sclk` at its idle level.
- R7: With `cpol` = 1 the idle level of `sclk` is 1 and the active level is 0. With `cpol` = 0 the idle level is 0 and the active level is 1.
- R8: After `en` is sampled low, `sclk` shows `cpol` and both strobes are low from the next edge. The accumulator and half-period state are cleared, so a later enable repeats the R3 timing exactly, even if the clock was stopped mid-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the clock idle and clears the phase |
| cpol | input | 1 | Idle level of the serial clock |
| sel | input | 3 | Index of the active chip select |
| rate_words | input | 64 | Rate fields of all chip selects, 8 bits each, select i at bits 8i+7:8i |
| sclk | output | 1 | Serial bit clock (registered) |
| lead_stb | output | 1 | One-cycle strobe at each leading clock edge |
| trail_stb | output | 1 | One-cycle strobe at each trailing clock edge |

## Verification
The rate field passes through one selection register, the accumulator carry is registered, and the edge stage adds one more register. As a result, a strobe due to the n-th carry appears after core edge n+1, counted from the first edge with `en` high. The bench's driver turns each configuration into a queue of expected strobe edges at 256/R + 1 + k·256/R, alternating lead and trail. The monitor counts enabled edges itself and samples 2 ns after each rising edge; it pops an expected strobe exactly when its edge count matches. The bench configures each rate field at least three cycles before enabling. Idle checks begin one edge after `en` is seen low, which matches the single register between `en` and the outputs.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  // One-cycle edge markers handed to the shifter
  typedef struct packed {
    logic lead;
    logic trail;
  } edge_stb_t;

  // Rate field width and the accumulator that wraps at 2**(RATE_W+1)
  localparam int DEF_RATE_W = 8;
  localparam int DEF_NUM_SEL = 8;
endpackage

// File: rtl/bitclk_rate_sel.sv
module bitclk_rate_sel #(
  parameter int NUM_SEL = 8,
  parameter int RATE_W  = 8,
  parameter int SEL_W   = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SEL_W-1:0]          sel,
  input  logic [NUM_SEL*RATE_W-1:0] rate_words,
  output logic [RATE_W-1:0]         rate_q
);

  logic [RATE_W-1:0] fields [NUM_SEL];

  // Split the packed field vector into one entry per chip select
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_field
    assign fields[i] = rate_words[i*RATE_W +: RATE_W];
  end

  // Keep only the highest set bit so that the step is a power of two
  function automatic logic [RATE_W-1:0] floor_pow2(input logic [RATE_W-1:0] v);
    logic [RATE_W-1:0] r;
    r = '0;
    for (int b = 0; b < RATE_W; b++) begin
      if (v[b]) begin
        r    = '0;
        r[b] = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
    end else begin
      rate_q <= floor_pow2(fields[sel]);
    end
  end

  // R6: the step reaching the accumulator is zero or a single power of two
  assert_rate_pow2_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rate_q));

endmodule

// File: rtl/bitclk_accum.sv
module bitclk_accum #(
  parameter int RATE_W = 8,
  parameter int ACC_W  = RATE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              wrap
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  // Step is twice the rate field: each carry is a half period,
  // so a full period spans 2**ACC_W / rate core cycles.
  assign sum = {1'b0, acc} + {1'b0, rate, 1'b0};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc  <= '0;
      wrap <= 1'b0;
    end else begin
      acc  <= sum[ACC_W-1:0];
      wrap <= sum[ACC_W];
    end
  end

  // R2: a power-of-two step of at most half the range never carries twice in a row
  assert_wrap_spaced_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);

  // R8: a cleared accumulator produces no carry on the cycle after disable
  assert_wrap_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !wrap);

endmodule

// File: rtl/bitclk_edge_gen.sv
module bitclk_edge_gen
  import bitclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      cpol,
  input  logic      wrap,
  output logic      sclk,
  output edge_stb_t stb
);

  // phase = 1 while the clock is at its active level
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase     <= 1'b0;
      sclk      <= cpol;
      stb.lead  <= 1'b0;
      stb.trail <= 1'b0;
    end else begin
      stb.lead  <= wrap && !phase;
      stb.trail <= wrap && phase;
      if (wrap) begin
        phase <= !phase;
      end
      sclk <= cpol ^ (phase ^ wrap);
    end
  end

  // R4: leading and trailing strobes are exclusive
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(stb.lead && stb.trail));

  // R4/R7: a leading strobe coincides with the active level, a trailing one with idle
  assert_lead_active_R4: assert property (@(posedge clk) disable iff (rst)
    stb.lead |-> (sclk != $past(cpol)));
  assert_trail_idle_R7: assert property (@(posedge clk) disable iff (rst)
    stb.trail |-> (sclk == $past(cpol)));

  // R8: disabling parks the clock at the idle level with no strobes
  assert_idle_park_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sclk == $past(cpol)) && !stb.lead && !stb.trail);

  // R1: reset holds the idle level
  always_ff @(posedge clk) begin
    if (!rst && $past(rst)) begin
      assert_reset_idle_R1: assert (sclk == $past(cpol) && !stb.lead && !stb.trail);
    end
  end

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int NUM_SEL = DEF_NUM_SEL,
  parameter int RATE_W  = DEF_RATE_W,
  parameter int SEL_W   = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      cpol,
  input  logic [SEL_W-1:0]          sel,
  input  logic [NUM_SEL*RATE_W-1:0] rate_words,
  output logic                      sclk,
  output logic                      lead_stb,
  output logic                      trail_stb
);

  localparam int ACC_W = RATE_W + 1;

  logic [RATE_W-1:0] rate_q;
  logic              wrap;
  edge_stb_t         stb;

  bitclk_rate_sel #(
    .NUM_SEL (NUM_SEL),
    .RATE_W  (RATE_W),
    .SEL_W   (SEL_W)
  ) u_rate_sel (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .rate_words (rate_words),
    .rate_q     (rate_q)
  );

  bitclk_accum #(
    .RATE_W (RATE_W),
    .ACC_W  (ACC_W)
  ) u_accum (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .rate (rate_q),
    .wrap (wrap)
  );

  bitclk_edge_gen u_edge (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .cpol (cpol),
    .wrap (wrap),
    .sclk (sclk),
    .stb  (stb)
  );

  assign lead_stb  = stb.lead;
  assign trail_stb = stb.trail;

endmodule

// File: tb/bitclk_gen_bench.sv
module bitclk_gen_bench;
  localparam int NUM_SEL = 8;
  localparam int RATE_W  = 8;
  localparam int SEL_W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cpol = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [NUM_SEL*RATE_W-1:0] words = '0;
  logic sclk, lead_stb, trail_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit en_q = 1'b0;
  bit act = 1'b0;
  bit mon_on = 1'b0;
  string tag = "R1";
  int q_cyc[$];
  bit q_lead[$];

  always #4 clk = ~clk;

  bitclk_gen #(.NUM_SEL(NUM_SEL), .RATE_W(RATE_W), .SEL_W(SEL_W)) u_bitclk_gen (
    .clk(clk), .rst(rst), .en(en), .cpol(cpol), .sel(sel),
    .rate_words(words), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(bit ok, string what, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
    end
  endtask

  // Field of select s gets f, every other field gets a distinct nonzero value (R5)
  function automatic logic [NUM_SEL*RATE_W-1:0] pack(int s, logic [RATE_W-1:0] f);
    logic [NUM_SEL*RATE_W-1:0] w;
    for (int i = 0; i < NUM_SEL; i++) begin
      w[i*RATE_W +: RATE_W] = (i == s) ? f : RATE_W'(i * 37 + 3);
    end
    return w;
  endfunction

  // Monitor: counts enabled edges, pops expected strobes when due
  initial forever begin
    @(posedge clk);
    if (en) cyc++; else cyc = 0;
    en_q = en;
    #2;
    if (mon_on) begin
      if (!en_q) begin
        act = 1'b0;
        check(sclk == cpol && !lead_stb && !trail_stb, "idle level R8",
              {sclk, lead_stb, trail_stb}, {cpol, 2'b00});
      end else begin
        bit exp_l;
        bit exp_t;
        exp_l = 1'b0;
        exp_t = 1'b0;
        if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
          exp_l = q_lead[0];
          exp_t = !q_lead[0];
          void'(q_cyc.pop_front());
          void'(q_lead.pop_front());
        end
        check(lead_stb == exp_l && trail_stb == exp_t,
              $sformatf("strobes at edge %0d (R2 R3 R4)", cyc),
              {lead_stb, trail_stb}, {exp_l, exp_t});
        if (exp_l) act = 1'b1;
        if (exp_t) act = 1'b0;
        check(sclk == (cpol ^ act), "clock level R4 R7", sclk, cpol ^ act);
      end
    end
  end

  // Driver: configure, push expected strobe edges, run, then disable
  task automatic run(string t, int s, logic [NUM_SEL*RATE_W-1:0] w, bit pol, int eff);
    int n;
    int win;
    @(negedge clk);
    tag = t;
    sel = s[SEL_W-1:0];
    words = w;
    cpol = pol;
    en = 1'b0;
    repeat (3) @(negedge clk);
    n = (eff == 0) ? 0 : 256 / eff;
    win = (eff == 0) ? 600 : 5 * n + 3;
    if (eff != 0) begin
      for (int m = 0; (n + 1 + 2 * n * m) <= win; m++) begin
        q_cyc.push_back(n + 1 + 2 * n * m);
        q_lead.push_back(1'b1);
        if ((2 * n + 1 + 2 * n * m) <= win) begin
          q_cyc.push_back(2 * n + 1 + 2 * n * m);
          q_lead.push_back(1'b0);
        end
      end
    end
    en = 1'b1;
    repeat (win) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check(q_cyc.size() == 0, "missing strobes", q_cyc.size(), 0);
    q_cyc.delete();
    q_lead.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(sclk == 1'b0 && !lead_stb && !trail_stb, "reset state R1",
          {sclk, lead_stb, trail_stb}, 0);
    rst = 1'b0;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);
    run("R2 R3 R5 fast",      0, pack(0, 8'd128), 1'b0, 128);
    run("R7 R5 cpol1",        3, pack(3, 8'd32),  1'b1, 32);
    run("R2 slowest",         7, pack(7, 8'd1),   1'b0, 1);
    run("R6 round 0x50",      5, pack(5, 8'h50),  1'b0, 64);
    run("R6 round 0x05",      2, pack(2, 8'h05),  1'b1, 4);
    run("R6 zero field",      1, pack(1, 8'h00),  1'b0, 0);
    run("R8 restart first",   6, pack(6, 8'd16),  1'b1, 16);
    run("R8 restart again",   6, pack(6, 8'd16),  1'b1, 16);
    run("R5 R7 select 4",     4, pack(4, 8'd2),   1'b0, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule